// File: doc/BRIEF.md
# Memory operand address generator

This block turns the addressing bytes of an instruction into a memory operand location. It takes the operand-descriptor byte, an optional scale/index/base byte and zero to four displacement bytes, one per cycle, through a valid/ready handshake. For the result it uses the eight general registers supplied on a flat input bus, an address-size flag and one-hot segment-override inputs. The address-size flag and the override inputs are sampled together with the first byte.

When the last byte has been taken, the block raises a one-cycle done strobe. During that cycle it presents the effective offset, a segment selector code, the number of bytes consumed and an error flag for conflicting overrides. For register-direct operands it reports only that the operand is a register and gives its index. Operand fetch and the register file are handled elsewhere.

The controller is a four-state machine with these states:
- WAIT_MODRM: the reset and idle state.
- WAIT_SIB: waits for the scale/index/base byte.
- WAIT_DISP: collects the displacement bytes.
- RESULT: presents the result for one cycle.

The machine moves between the states along these transitions:
- T_DIRECT: WAIT_MODRM to RESULT, for a register operand or when no further bytes are needed.
- T_TO_SIB: WAIT_MODRM to WAIT_SIB.
- T_TO_DISP: WAIT_MODRM to WAIT_DISP.
- T_SIB_DISP: WAIT_SIB to WAIT_DISP.
- T_SIB_END: WAIT_SIB to RESULT.
- T_DISP_NEXT: WAIT_DISP to WAIT_DISP.
- T_DISP_END: WAIT_DISP to RESULT.
- T_RETURN: RESULT to WAIT_MODRM.

Top module: `eamg_top`

## Requirements
- R1: The descriptor byte is split into mode (bits 7:6), register field (bits 5:3) and r/m field (bits 2:0). `reg_field` and `rm_field` report the last two at done.
- R2: The general-register bus carries registers 0..7 = AX, CX, DX, BX, SP, BP, SI, DI, with register n at bits 32n+31:32n. In 16-bit mode, r/m 0..7 selects BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. The offset is the sum modulo 2^16, zero-extended.
- R3: In 16-bit mode, mode 0 with r/m 6 uses a 16-bit displacement alone and no BP.
- R4: Displacement bytes arrive least significant byte first. Mode 1 adds an 8-bit displacement, sign-extended. Mode 2 adds a 16-bit displacement in 16-bit mode and a 32-bit displacement in 32-bit mode.
- R5: With no override, the segment code is SS (2) for a BP/EBP/ESP-based form and DS (3) otherwise. The segment codes are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5.
- R6: In 32-bit mode, r/m 4 means a scale/index/base byte follows. Mode 0 with r/m 5 gives an absolute 32-bit displacement. Every other form adds the selected register to the displacement, modulo 2^32.
- R7: In the scale/index/base byte, bits 7:6 give the factor 1/2/4/8, bits 5:3 the index and bits 2:0 the base. Index 4 means no index. Base 5 with mode 0 takes a 32-bit displacement in place of a base. The byte is consumed before any displacement.
- R8: One asserted override bit (bit i = segment code i) replaces the implicit segment.
- R9: More than one asserted override bit raises `seg_err` at done.
- R10: Mode 3 ends after the descriptor byte with `reg_direct`=1 and offset 0.
- R11: `bytes_used` equals 1, plus 1 if a scale/index/base byte was taken, plus the displacement length.
- R12: `done` is a single-cycle pulse in the cycle after the last byte is accepted. `byte_ready` is low only during that cycle, and both are at their idle values (done 0, ready 1) after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | Instruction byte present |
| byte_data | input | 8 | Instruction byte |
| byte_ready | output | 1 | Block can take a byte |
| mode32 | input | 1 | 32-bit address size, sampled with the descriptor byte |
| seg_ovr | input | NUM_SEG | One-hot segment override, sampled with the descriptor byte |
| gpr_flat | input | NUM_GPR*GPR_W | General registers, held stable during a request |
| done | output | 1 | Result valid strobe |
| ea_offset | output | GPR_W | Effective offset |
| seg_sel | output | 3 | Segment code |
| bytes_used | output | 3 | Bytes consumed |
| seg_err | output | 1 | Conflicting overrides |
| reg_direct | output | 1 | Operand is a register |
| reg_field | output | 3 | Register field of the descriptor |
| rm_field | output | 3 | r/m field of the descriptor |

## Verification
The bench builds the block with its default parameters: 32-bit registers, eight of them, and six segment codes. These are the only values at which the 16-bit wrap, the 32-bit scale/index/base path and a full-length four-byte displacement all fall within the same instance. With these values the bench reaches the longest request, six bytes, and every exit from the state machine. It also reaches both the implicit SS cases and the override conflict.

// File: rtl/eamg_pkg.sv
package eamg_pkg;
    localparam int BYTE_W   = 8;
    localparam int MAX_DISP = 4;
    localparam int LEN_W    = 3;

    typedef enum logic [1:0] {
        WAIT_MODRM = 2'd0,
        WAIT_SIB   = 2'd1,
        WAIT_DISP  = 2'd2,
        RESULT     = 2'd3
    } ea_state_t;

    localparam logic [2:0] SEG_SS = 3'd2;
    localparam logic [2:0] SEG_DS = 3'd3;
endpackage

// File: rtl/eamg_ctl.sv
module eamg_ctl
    import eamg_pkg::*;
#(
    parameter int NUM_SEG = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_valid,
    input  logic [BYTE_W-1:0]  byte_data,
    input  logic               mode32_in,
    input  logic [NUM_SEG-1:0] seg_ovr_in,
    output logic               byte_ready,
    output logic               done,
    output logic               modrm_take,
    output logic               disp_take,
    output logic [1:0]         disp_idx,
    output logic [1:0]         mod_q,
    output logic [2:0]         reg_q,
    output logic [2:0]         rm_q,
    output logic [BYTE_W-1:0]  sib_q,
    output logic               mode32_q,
    output logic [NUM_SEG-1:0] ovr_q,
    output logic [LEN_W-1:0]   disp_len_q,
    output logic [LEN_W-1:0]   bytes_used
);
    ea_state_t        state_q, state_d;
    logic [LEN_W-1:0] len_d;
    logic [1:0]       cnt_q;
    logic             has_sib_q;
    logic             accept;
    logic             need_sib;

    assign accept   = byte_valid && byte_ready;
    assign need_sib = mode32_in && (byte_data[7:6] != 2'd3) && (byte_data[2:0] == 3'd4);

    function automatic logic [LEN_W-1:0] first_len(input logic [1:0] m, input logic [2:0] r,
                                                   input logic wide);
        logic [LEN_W-1:0] n;
        unique case (m)
            2'd0:    n = wide ? ((r == 3'd5) ? LEN_W'(4) : '0) : ((r == 3'd6) ? LEN_W'(2) : '0);
            2'd1:    n = LEN_W'(1);
            2'd2:    n = wide ? LEN_W'(4) : LEN_W'(2);
            default: n = '0;
        endcase
        return n;
    endfunction

    // next state
    always_comb begin
        state_d = state_q;
        len_d   = disp_len_q;
        unique case (state_q)
            WAIT_MODRM: if (accept) begin
                len_d = first_len(byte_data[7:6], byte_data[2:0], mode32_in);
                if (byte_data[7:6] == 2'd3)      state_d = RESULT;    // T_DIRECT
                else if (need_sib)               state_d = WAIT_SIB;  // T_TO_SIB
                else if (len_d != '0)            state_d = WAIT_DISP; // T_TO_DISP
                else                             state_d = RESULT;    // T_DIRECT
            end
            WAIT_SIB: if (accept) begin
                if (mod_q == 2'd0 && byte_data[2:0] == 3'd5) len_d = LEN_W'(4);
                state_d = (len_d != '0) ? WAIT_DISP : RESULT;         // T_SIB_DISP / T_SIB_END
            end
            WAIT_DISP: if (accept) begin
                if ((LEN_W'(cnt_q) + LEN_W'(1)) == disp_len_q) state_d = RESULT; // T_DISP_END
            end
            RESULT:    state_d = WAIT_MODRM;                          // T_RETURN
            default:   state_d = WAIT_MODRM;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WAIT_MODRM;
        else        state_q <= state_d;
    end

    // captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q <= '0; reg_q <= '0; rm_q <= '0; sib_q <= '0;
            mode32_q <= 1'b0; ovr_q <= '0; disp_len_q <= '0;
            cnt_q <= '0; has_sib_q <= 1'b0;
        end else if (accept) begin
            unique case (state_q)
                WAIT_MODRM: begin
                    mod_q      <= byte_data[7:6];
                    reg_q      <= byte_data[5:3];
                    rm_q       <= byte_data[2:0];
                    mode32_q   <= mode32_in;
                    ovr_q      <= seg_ovr_in;
                    sib_q      <= '0;
                    has_sib_q  <= need_sib;
                    disp_len_q <= len_d;
                    cnt_q      <= '0;
                end
                WAIT_SIB: begin
                    sib_q      <= byte_data;
                    disp_len_q <= len_d;
                end
                WAIT_DISP: cnt_q <= cnt_q + 2'd1;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        byte_ready = (state_q != RESULT);
        done       = (state_q == RESULT);
        modrm_take = accept && (state_q == WAIT_MODRM);
        disp_take  = accept && (state_q == WAIT_DISP);
        disp_idx   = cnt_q;
        bytes_used = LEN_W'(1) + LEN_W'(has_sib_q) + disp_len_q;
    end
endmodule

// File: rtl/eamg_disp.sv
module eamg_disp
    import eamg_pkg::*;
#(
    parameter int GPR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [1:0]        idx,
    input  logic [BYTE_W-1:0] din,
    input  logic [LEN_W-1:0]  len,
    output logic [GPR_W-1:0]  disp
);
    logic [BYTE_W-1:0] lane_q [MAX_DISP];

    for (genvar g = 0; g < MAX_DISP; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          lane_q[g] <= '0;
            else if (clear)                      lane_q[g] <= '0;
            else if (take && idx == 2'(g))       lane_q[g] <= din;
        end
    end

    always_comb begin
        unique case (len)
            LEN_W'(1): disp = GPR_W'($signed(lane_q[0]));
            LEN_W'(2): disp = GPR_W'($signed({lane_q[1], lane_q[0]}));
            LEN_W'(4): disp = GPR_W'({lane_q[3], lane_q[2], lane_q[1], lane_q[0]});
            default:   disp = '0;
        endcase
    end
endmodule

// File: rtl/eamg_addr.sv
module eamg_addr #(
    parameter int GPR_W   = 32,
    parameter int NUM_GPR = 8
) (
    input  logic [NUM_GPR*GPR_W-1:0] gpr_flat,
    input  logic [1:0]               mod_f,
    input  logic [2:0]               rm_f,
    input  logic [7:0]               sib,
    input  logic                     wide,
    input  logic [GPR_W-1:0]         disp,
    output logic [GPR_W-1:0]         offset,
    output logic                     stack_based
);
    localparam int HALF = 16;
    localparam int RBX = 3, RSP = 4, RBP = 5, RSI = 6, RDI = 7;

    logic [GPR_W-1:0] r [NUM_GPR];
    for (genvar g = 0; g < NUM_GPR; g++) begin : g_unpack
        assign r[g] = gpr_flat[g*GPR_W +: GPR_W];
    end

    logic [HALF-1:0]  narrow_sum;
    logic [GPR_W-1:0] base_v, index_v;
    logic [2:0]       b_code, i_code;

    assign b_code = sib[2:0];
    assign i_code = sib[5:3];

    always_comb begin
        offset      = '0;
        stack_based = 1'b0;
        narrow_sum  = '0;
        base_v      = '0;
        index_v     = '0;
        if (mod_f == 2'd3) begin
            offset = '0;
        end else if (!wide) begin
            unique case (rm_f)
                3'd0: narrow_sum = r[RBX][HALF-1:0] + r[RSI][HALF-1:0];
                3'd1: narrow_sum = r[RBX][HALF-1:0] + r[RDI][HALF-1:0];
                3'd2: begin narrow_sum = r[RBP][HALF-1:0] + r[RSI][HALF-1:0]; stack_based = 1'b1; end
                3'd3: begin narrow_sum = r[RBP][HALF-1:0] + r[RDI][HALF-1:0]; stack_based = 1'b1; end
                3'd4: narrow_sum = r[RSI][HALF-1:0];
                3'd5: narrow_sum = r[RDI][HALF-1:0];
                3'd6: if (mod_f != 2'd0) begin
                          narrow_sum  = r[RBP][HALF-1:0];
                          stack_based = 1'b1;
                      end
                default: narrow_sum = r[RBX][HALF-1:0];
            endcase
            offset = GPR_W'(HALF'(narrow_sum + disp[HALF-1:0]));
        end else if (rm_f == 3'd4) begin
            if (b_code == 3'd5 && mod_f == 2'd0) base_v = '0;
            else                                 base_v = r[b_code];
            stack_based = (b_code == 3'(RSP)) || (b_code == 3'(RBP) && mod_f != 2'd0);
            if (i_code != 3'(RSP)) index_v = r[i_code] << sib[7:6];
            offset = base_v + index_v + disp;
        end else if (rm_f == 3'd5 && mod_f == 2'd0) begin
            offset = disp;
        end else begin
            offset      = r[rm_f] + disp;
            stack_based = (rm_f == 3'(RBP));
        end
    end
endmodule

// File: rtl/eamg_seg.sv
module eamg_seg
    import eamg_pkg::*;
#(
    parameter int NUM_SEG = 6
) (
    input  logic [NUM_SEG-1:0] ovr,
    input  logic               stack_based,
    output logic [2:0]         seg_code,
    output logic               conflict
);
    logic [$clog2(NUM_SEG+1)-1:0] hits;

    always_comb begin
        hits     = '0;
        seg_code = stack_based ? SEG_SS : SEG_DS;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (ovr[i]) begin
                hits = hits + 1'b1;
                seg_code = 3'(i);
            end
        end
        conflict = (hits > 1);
        if (conflict) seg_code = SEG_DS;
    end
endmodule

// File: rtl/eamg_top.sv
module eamg_top
    import eamg_pkg::*;
#(
    parameter int GPR_W   = 32,
    parameter int NUM_GPR = 8,
    parameter int NUM_SEG = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     byte_valid,
    input  logic [7:0]               byte_data,
    output logic                     byte_ready,
    input  logic                     mode32,
    input  logic [NUM_SEG-1:0]       seg_ovr,
    input  logic [NUM_GPR*GPR_W-1:0] gpr_flat,
    output logic                     done,
    output logic [GPR_W-1:0]         ea_offset,
    output logic [2:0]               seg_sel,
    output logic [2:0]               bytes_used,
    output logic                     seg_err,
    output logic                     reg_direct,
    output logic [2:0]               reg_field,
    output logic [2:0]               rm_field
);
    logic               modrm_take, disp_take, mode32_q, stack_based;
    logic [1:0]         disp_idx, mod_q;
    logic [2:0]         reg_q, rm_q;
    logic [7:0]         sib_q;
    logic [NUM_SEG-1:0] ovr_q;
    logic [LEN_W-1:0]   disp_len_q;
    logic [GPR_W-1:0]   disp_v;

    eamg_ctl #(.NUM_SEG(NUM_SEG)) ctl_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .mode32_in(mode32), .seg_ovr_in(seg_ovr), .byte_ready(byte_ready), .done(done),
        .modrm_take(modrm_take), .disp_take(disp_take), .disp_idx(disp_idx),
        .mod_q(mod_q), .reg_q(reg_q), .rm_q(rm_q), .sib_q(sib_q), .mode32_q(mode32_q),
        .ovr_q(ovr_q), .disp_len_q(disp_len_q), .bytes_used(bytes_used)
    );

    eamg_disp #(.GPR_W(GPR_W)) disp_i (
        .clk(clk), .rst_n(rst_n), .clear(modrm_take), .take(disp_take), .idx(disp_idx),
        .din(byte_data), .len(disp_len_q), .disp(disp_v)
    );

    eamg_addr #(.GPR_W(GPR_W), .NUM_GPR(NUM_GPR)) addr_i (
        .gpr_flat(gpr_flat), .mod_f(mod_q), .rm_f(rm_q), .sib(sib_q), .wide(mode32_q),
        .disp(disp_v), .offset(ea_offset), .stack_based(stack_based)
    );

    eamg_seg #(.NUM_SEG(NUM_SEG)) seg_i (
        .ovr(ovr_q), .stack_based(stack_based), .seg_code(seg_sel), .conflict(seg_err)
    );

    assign reg_direct = (mod_q == 2'd3);
    assign reg_field  = reg_q;
    assign rm_field   = rm_q;
endmodule

// File: rtl/eamg_chk.sv
module eamg_chk #(
    parameter int GPR_W   = 32,
    parameter int NUM_SEG = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic               byte_ready,
    input logic [2:0]         bytes_used,
    input logic               reg_direct,
    input logic [GPR_W-1:0]   ea_offset,
    input logic               mode32_q,
    input logic               seg_err,
    input logic [2:0]         seg_sel,
    input logic [NUM_SEG-1:0] ovr_q
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                        // R12
    AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !byte_ready);                                                  // R12
    AST_USED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bytes_used >= 3'd1 && bytes_used <= 3'd6));                   // R11
    AST_DIRECT_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && reg_direct) |-> (bytes_used == 3'd1 && ea_offset == '0));      // R10
    AST_NARROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode32_q) |-> (ea_offset[GPR_W-1:16] == '0));                 // R2
    AST_MULTI_OVR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seg_err == ($countones(ovr_q) > 1)));                         // R9
    AST_OVR_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $countones(ovr_q) == 1) |-> (seg_sel < NUM_SEG && ovr_q[seg_sel])); // R8
endmodule

bind eamg_top eamg_chk #(.GPR_W(GPR_W), .NUM_SEG(NUM_SEG)) chk_i (
    .clk(clk), .rst_n(rst_n), .done(done), .byte_ready(byte_ready),
    .bytes_used(bytes_used), .reg_direct(reg_direct), .ea_offset(ea_offset),
    .mode32_q(mode32_q), .seg_err(seg_err), .seg_sel(seg_sel), .ovr_q(ovr_q)
);

// File: tb/eamg_top_tb.sv
`timescale 1ns/1ps
module eamg_top_tb_top;
    localparam int  GPR_W = 32, NUM_GPR = 8, NUM_SEG = 6;
    localparam time TCK   = 20ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic byte_valid = 1'b0, mode32 = 1'b0;
    logic [7:0] byte_data = '0;
    logic [NUM_SEG-1:0] seg_ovr = '0;
    logic [GPR_W-1:0] gpr [NUM_GPR];
    logic [NUM_GPR*GPR_W-1:0] gpr_flat;
    logic byte_ready, done, seg_err, reg_direct;
    logic [GPR_W-1:0] ea_offset;
    logic [2:0] seg_sel, bytes_used, reg_field, rm_field;
    int checks = 0, errors = 0;

    always #(TCK/2) clk = ~clk;

    always_comb for (int i = 0; i < NUM_GPR; i++) gpr_flat[i*GPR_W +: GPR_W] = gpr[i];

    eamg_top #(.GPR_W(GPR_W), .NUM_GPR(NUM_GPR), .NUM_SEG(NUM_SEG)) dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .mode32(mode32), .seg_ovr(seg_ovr), .gpr_flat(gpr_flat),
        .done(done), .ea_offset(ea_offset), .seg_sel(seg_sel), .bytes_used(bytes_used),
        .seg_err(seg_err), .reg_direct(reg_direct), .reg_field(reg_field), .rm_field(rm_field)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic clear_regs();
        for (int i = 0; i < NUM_GPR; i++) gpr[i] = '0;
    endtask

    // send request bytes (byte 0 in bits 7:0), then check the result cycle
    task automatic run(string tag, logic wide, logic [5:0] ovr, logic [47:0] bytes, int n,
                       logic [31:0] exp_off, logic [2:0] exp_seg, logic exp_err, logic exp_dir);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data  = bytes[8*i +: 8];
            mode32     = wide;
            seg_ovr    = ovr;
            while (!byte_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        chk({tag, " R12 done"}, 32'(done), 32'd1);
        chk({tag, " R11 bytes_used"}, 32'(bytes_used), 32'(n));
        chk({tag, " R10 reg_direct"}, 32'(reg_direct), 32'(exp_dir));
        chk({tag, " offset"}, ea_offset, exp_off);
        if (!exp_dir) chk({tag, " R5 seg"}, 32'(seg_sel), 32'(exp_seg));
        chk({tag, " R9 seg_err"}, 32'(seg_err), 32'(exp_err));
        chk({tag, " R12 ready low"}, 32'(byte_ready), 32'd0);
        @(negedge clk);
        chk({tag, " R12 done pulse"}, 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        chk("R12 reset done", 32'(done), 32'd0);
        chk("R12 reset ready", 32'(byte_ready), 32'd1);
    endtask

    task automatic t_narrow_wrap();  // R2
        clear_regs(); gpr[3] = 32'hFFF0; gpr[6] = 32'h0020;
        run("R2 bx+si wrap", 1'b0, 6'b0, 48'h00, 1, 32'h0010, 3'd3, 1'b0, 1'b0);
    endtask

    task automatic t_narrow_direct();  // R3
        clear_regs(); gpr[5] = 32'h5555;
        run("R3 direct", 1'b0, 6'b0, 48'h12_3406, 3, 32'h1234, 3'd3, 1'b0, 1'b0);
    endtask

    task automatic t_narrow_bp8();  // R4 R5
        clear_regs(); gpr[5] = 32'h0100;
        run("R4 bp disp8 neg", 1'b0, 6'b0, 48'hFE46, 2, 32'h00FE, 3'd2, 1'b0, 1'b0);
    endtask

    task automatic t_narrow_bpdi16();  // R4 R5
        clear_regs(); gpr[5] = 32'h1000; gpr[7] = 32'h0010;
        run("R4 bp+di disp16", 1'b0, 6'b0, 48'h80_0083, 3, 32'h9010, 3'd2, 1'b0, 1'b0);
    endtask

    task automatic t_wide_abs();  // R6
        clear_regs(); gpr[5] = 32'hFFFF;
        run("R6 abs32", 1'b1, 6'b0, 48'h0012_3456_7805, 5, 32'h1234_5678, 3'd3, 1'b0, 1'b0);
    endtask

    task automatic t_wide_disp8();  // R4 R6
        clear_regs(); gpr[0] = 32'h1000_0000;
        run("R6 eax disp8", 1'b1, 6'b0, 48'h8040, 2, 32'h0FFF_FF80, 3'd3, 1'b0, 1'b0);
    endtask

    task automatic t_sib_scaled();  // R7
        clear_regs(); gpr[1] = 32'd3; gpr[3] = 32'h1000;
        run("R7 sib ebx+ecx*4", 1'b1, 6'b0, 48'h8B04, 2, 32'h100C, 3'd3, 1'b0, 1'b0);
    endtask

    task automatic t_sib_esp();  // R5 R7
        clear_regs(); gpr[4] = 32'h2000; gpr[0] = 32'hDEAD;
        run("R7 sib esp noidx", 1'b1, 6'b0, 48'h10_2444, 3, 32'h2010, 3'd2, 1'b0, 1'b0);
    endtask

    task automatic t_sib_nobase();  // R7
        clear_regs(); gpr[5] = 32'h7777; gpr[6] = 32'd2;
        run("R7 sib disp32 esi*8", 1'b1, 6'b0, 48'h0000_0100_F504, 6, 32'h0110, 3'd3, 1'b0, 1'b0);
    endtask

    task automatic t_sib_ebp();  // R5 R7
        clear_regs(); gpr[5] = 32'h3000;
        run("R7 sib ebp disp32", 1'b1, 6'b0, 48'h0000_0004_2584, 6, 32'h3004, 3'd2, 1'b0, 1'b0);
    endtask

    task automatic t_override();  // R8
        clear_regs(); gpr[5] = 32'h0100; gpr[6] = 32'h0002;
        run("R8 es override", 1'b0, 6'b000001, 48'h02, 1, 32'h0102, 3'd0, 1'b0, 1'b0);
    endtask

    task automatic t_conflict();  // R9 R1
        clear_regs(); gpr[3] = 32'h0042;
        run("R9 two overrides", 1'b0, 6'b010010, 48'h3F, 1, 32'h0042, 3'd3, 1'b1, 1'b0);
    endtask

    task automatic t_direct_reg();  // R10 R1
        clear_regs();
        @(negedge clk);
        byte_valid = 1'b1; byte_data = 8'hDA; mode32 = 1'b1; seg_ovr = '0;
        @(posedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
        chk("R10 direct done after 1 byte", 32'(done), 32'd1);
        chk("R10 reg_direct", 32'(reg_direct), 32'd1);
        chk("R10 offset zero", ea_offset, 32'd0);
        chk("R11 direct bytes", 32'(bytes_used), 32'd1);
        chk("R1 reg_field", 32'(reg_field), 32'd3);
        chk("R1 rm_field", 32'(rm_field), 32'd2);
        @(negedge clk);
    endtask

    initial begin
        #(TCK * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        clear_regs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_narrow_wrap();
        t_narrow_direct();
        t_narrow_bp8();
        t_narrow_bpdi16();
        t_wide_abs();
        t_wide_disp8();
        t_sib_scaled();
        t_sib_esp();
        t_sib_nobase();
        t_sib_ebp();
        t_override();
        t_conflict();
        t_direct_reg();
        report();
    end
endmodule